// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory that holds 2048 bytes. It watches the clock and data lines, which arrive already synchronized to the system clock. It recognizes start and stop conditions on the bus, shifts in the selection byte, and answers only when the selection byte's upper nibble holds the fixed device code. The three bits below that nibble are not compared with anything. They become the top three bits of the 11-bit memory address, so the target answers every selection byte in the `1010xxx` range.

A write carries three bytes: the selection byte with its direction bit at 0, a byte holding the low eight address bits, and one data byte. The target acknowledges all three. The data byte is stored at the 11-bit address only when a stop condition ends the transfer. A read uses a selection byte with its direction bit at 1. The target then shifts out the byte at its current address, most significant bit first, and the address steps by one after the controller's response bit. To read from a random address, a controller writes the address bytes, issues a repeated start, and sends a read selection byte.

The data line is driven open drain. The single output only pulls the line low, and the line is released at all other times.

Top module: `serial_mem_target`

## Requirements
- R1: During reset and after it is released, `sda_oe` is 0 and the target waits for a start condition.
- R2: A selection byte whose bits 7..4 equal 1010 is acknowledged: `sda_oe` is 1 for the whole ninth clock period, from the falling edge after bit 8 to the next falling edge.
- R3: A selection byte whose bits 7..4 differ from 1010 gets no acknowledge. The target then ignores every bit, and acknowledges no byte, until the next start condition.
- R4: Write: the selection byte (bit 0 = 0, bits 3..1 = address bits 10..8), the low address byte and one data byte are each acknowledged. The data byte is stored at that 11-bit address when a stop condition follows.
- R5: Read: after a selection byte with bit 0 = 1 is acknowledged, the target presents the byte at its current address, most significant bit first. It changes `sda_oe` only while SCL is low.
- R6: In a read, the address steps by one (wrapping modulo 2048) on the rising clock edge of the controller's response bit. The next read with the same bits 3..1 in its selection byte returns that next byte.
- R7: A stop condition in the middle of a data byte ends the transfer, and nothing is stored.
- R8: A start condition in any state, including the middle of a byte, restarts selection-byte matching. A read selection byte that follows reads from the address loaded before the restart.
- R9: In a write, bytes that come after the first data byte are not acknowledged and do not change the stored value.
- R10: A write whose data byte is followed by a start condition instead of a stop is discarded.
- R11: When no transfer is in progress, the data line is released (`sda_oe` = 0).
- R12: Bits 3..1 of the selection byte choose among eight 256-byte banks. The same low address in different banks holds independent bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock level, already synchronized |
| sda_i | input | 1 | Serial data line level (wired bus value), already synchronized |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A corrupted bit counter or control state shows on the bus within one byte. It appears as an acknowledge that is missing, or that lands one clock early or late, on the ninth clock of the byte in progress. A wrong address or shift register stays hidden until the next read, where it shows as a wrong data byte or a reversed bit order. For that reason every write in the bench is followed by a read of the same address. A write committed at the wrong moment shows only when that location is read back after an aborted or extended transfer, so each abort case ends with such a read.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = 3;
  localparam int unsigned ADDR_W = BYTE_W + HI_W;
  localparam int unsigned CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RD,
    ST_RRESP,
    ST_HOLD
  } smt_state_e;
endpackage

// File: rtl/smt_cond_detect.sv
module smt_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic scl_hi_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    start_o    = scl_q & scl_i & sda_q & ~sda_i;
    stop_o     = scl_q & scl_i & ~sda_q & sda_i;
    scl_rise_o = ~scl_q & scl_i;
    scl_fall_o = scl_q & ~scl_i;
    scl_hi_o   = scl_q;
  end
endmodule

// File: rtl/smt_store.sv
module smt_store
  import smt_pkg::*;
(
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      cells[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/smt_ctrl.sv
module smt_ctrl
  import smt_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              scl_hi_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              we_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  smt_state_e        st, st_n, aft, aft_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, rsh, rsh_n, wd, wd_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              wp, wp_n, oe, oe_n;

  always_comb begin
    st_n   = st;
    aft_n  = aft;
    cnt_n  = cnt;
    sh_n   = sh;
    rsh_n  = rsh;
    wd_n   = wd;
    addr_n = addr;
    wp_n   = wp;
    oe_n   = oe;
    if (stop_i) begin
      st_n  = ST_IDLE;
      oe_n  = 1'b0;
      wp_n  = 1'b0;
      cnt_n = '0;
    end else if (start_i) begin
      st_n  = ST_SEL;
      oe_n  = 1'b0;
      wp_n  = 1'b0;
      cnt_n = '0;
    end else begin
      case (st)
        ST_SEL, ST_WADDR, ST_WDATA: begin
          if (scl_rise_i && cnt != FULL) begin
            sh_n  = {sh[BYTE_W-2:0], sda_i};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall_i && cnt == FULL) begin
            cnt_n = '0;
            if (st == ST_SEL) begin
              if (sh[7:4] == DEV_CODE) begin
                addr_n[ADDR_W-1:BYTE_W] = sh[HI_W:1];
                aft_n = sh[0] ? ST_RD : ST_WADDR;
                oe_n  = 1'b1;
                st_n  = ST_ACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              addr_n[BYTE_W-1:0] = sh;
              aft_n = ST_WDATA;
              oe_n  = 1'b1;
              st_n  = ST_ACK;
            end else begin
              wd_n  = sh;
              wp_n  = 1'b1;
              aft_n = ST_HOLD;
              oe_n  = 1'b1;
              st_n  = ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            st_n = aft;
            if (aft == ST_RD) begin
              rsh_n = rdata_i;
              oe_n  = ~rdata_i[BYTE_W-1];
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall_i) begin
            if (cnt == FULL) begin
              oe_n  = 1'b0;
              cnt_n = '0;
              st_n  = ST_RRESP;
            end else begin
              rsh_n = {rsh[BYTE_W-2:0], 1'b0};
              oe_n  = ~rsh[BYTE_W-2];
            end
          end
        end
        ST_RRESP: begin
          if (scl_rise_i) begin
            addr_n = addr + 1'b1;
            st_n   = ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      aft  <= ST_IDLE;
      cnt  <= '0;
      sh   <= '0;
      rsh  <= '0;
      wd   <= '0;
      addr <= '0;
      wp   <= 1'b0;
      oe   <= 1'b0;
    end else begin
      st   <= st_n;
      aft  <= aft_n;
      cnt  <= cnt_n;
      sh   <= sh_n;
      rsh  <= rsh_n;
      wd   <= wd_n;
      addr <= addr_n;
      wp   <= wp_n;
      oe   <= oe_n;
    end
  end

  assign we_o     = stop_i & (st == ST_HOLD) & wp;
  assign addr_o   = addr;
  assign wdata_o  = wd;
  assign sda_oe_o = oe;

  p_oe_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_hi_i);
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !oe);
  p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (st == ST_SEL && cnt == '0));
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (st == ST_IDLE && !oe));
  p_nomatch_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEL && scl_fall_i && cnt == FULL && sh[7:4] != DEV_CODE && !start_i && !stop_i)
    |=> (st == ST_IDLE && !oe));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target
  import smt_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic rst_meta, rst_sync;
  logic start, stop, scl_rise, scl_fall, scl_hi;
  logic we;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  smt_cond_detect u_cond (
    .clk        (clk),
    .rst_n      (rst_sync),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .scl_hi_o   (scl_hi)
  );

  smt_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .scl_hi_i   (scl_hi),
    .sda_i      (sda_i),
    .rdata_i    (rdata),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .we_o       (we),
    .sda_oe_o   (sda_oe)
  );

  smt_store u_store (
    .clk     (clk),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [2048];

  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {11'h000, 8'h1D}, {11'h123, 8'hC4}, {11'h124, 8'h36},
    {11'h7FF, 8'h8E}, {11'h500, 8'h12}, {11'h200, 8'h2B}
  };

  always #10 clk = ~clk;

  serial_mem_target u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack);
  endtask

  function automatic logic [7:0] sel(input logic [2:0] hi, input logic rd);
    return {4'b1010, hi, rd};
  endfunction

  task automatic write_one(input logic [10:0] a, input logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(sel(a[10:8], 1'b0), ack); chk(ack, "R2 select ack", ack, 1);
    send_byte(a[7:0], ack);             chk(ack, "R4 address ack", ack, 1);
    send_byte(d, ack);                  chk(ack, "R4 data ack", ack, 1);
    bus_stop();
  endtask

  task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(sel(a[10:8], 1'b0), ack); chk(ack, "R8 select ack", ack, 1);
    send_byte(a[7:0], ack);             chk(ack, "R8 address ack", ack, 1);
    bus_start();
    send_byte(sel(a[10:8], 1'b1), ack); chk(ack, "R8 read select ack", ack, 1);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  task automatic cur_read(input logic [2:0] hi, output logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(sel(hi, 1'b1), ack); chk(ack, "R5 read select ack", ack, 1);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic ack;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

    // Table walk: write every vector, then read each back (R4, R5, R12)
    for (int i = 0; i < NV; i++) begin
      write_one(VEC[i][18:8], VEC[i][7:0]);
      model[VEC[i][18:8]] = VEC[i][7:0];
      chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
    end
    for (int i = 0; i < NV; i++) begin
      rand_read(VEC[i][18:8], d);
      chk(d == model[VEC[i][18:8]], "R5 R12 read back", d, model[VEC[i][18:8]]);
    end

    // R6: address steps after the response bit, and wraps
    rand_read(11'h123, d);
    cur_read(3'd1, d);
    chk(d == model[11'h124], "R6 next address", d, model[11'h124]);
    rand_read(11'h7FF, d);
    cur_read(3'd0, d);
    chk(d == model[11'h000], "R6 wrap to zero", d, model[11'h000]);

    // R3: wrong device code, following bytes ignored
    bus_start();
    send_byte(8'hB0, ack); chk(!ack, "R3 no ack wrong code", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R3 ignored byte 1", ack, 0);
    send_byte(8'hEE, ack); chk(!ack, "R3 ignored byte 2", ack, 0);
    bus_stop();
    rand_read(11'h000, d);
    chk(d == model[11'h000], "R3 memory untouched", d, model[11'h000]);

    // R7: stop inside data byte
    bus_start();
    send_byte(sel(3'd1, 1'b0), ack);
    send_byte(8'h23, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    rand_read(11'h123, d);
    chk(d == model[11'h123], "R7 aborted write not stored", d, model[11'h123]);

    // R9: extra byte after data not acknowledged, first byte stored
    bus_start();
    send_byte(sel(3'd1, 1'b0), ack);
    send_byte(8'h24, ack);
    send_byte(8'h77, ack); chk(ack, "R9 data ack", ack, 1);
    send_byte(8'h99, ack); chk(!ack, "R9 extra byte no ack", ack, 0);
    bus_stop();
    model[11'h124] = 8'h77;
    rand_read(11'h124, d);
    chk(d == 8'h77, "R9 first byte kept", d, 8'h77);

    // R10: start instead of stop after data
    bus_start();
    send_byte(sel(3'd2, 1'b0), ack);
    send_byte(8'h00, ack);
    send_byte(8'h44, ack); chk(ack, "R10 data ack", ack, 1);
    bus_start();
    bus_stop();
    rand_read(11'h200, d);
    chk(d == model[11'h200], "R10 write discarded", d, model[11'h200]);

    // R8: restart in the middle of a data byte, then read
    bus_start();
    send_byte(sel(3'd5, 1'b0), ack);
    send_byte(8'h00, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start();
    send_byte(sel(3'd5, 1'b1), ack); chk(ack, "R8 select after restart", ack, 1);
    recv_byte(1'b1, d);
    bus_stop();
    chk(d == model[11'h500], "R8 read after restart", d, model[11'h500]);
    chk(sda_oe == 1'b0, "R11 idle released", sda_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule